// File: doc/BRIEF.md
# Goldschmidt Iterative Divider

This block divides one normalized 24-bit fixed-point value by another. It produces an approximate quotient with extra fraction bits and never forms an explicit reciprocal. Both operands are unsigned, with one integer bit and 23 fraction bits, in the range [1,2). A one-cycle `start_i` pulse captures them. The block first multiplies dividend and divisor by a reciprocal seed, which brings the divisor close to 1. It then runs a fixed number of refinement steps. Each step forms the correction factor 2 − d from the running divisor and multiplies both running values by it in the same cycle, using two truncating multipliers. The ratio of the two values stays the same, so the divisor converges to 1 and the dividend converges to the quotient.

The seed comes from a table with one entry per value of the leading divisor fraction bits. The entries are computed at elaboration. The prescale and the refinement steps share the same two multipliers, so the datapath has only multipliers and one subtractor. The result is an approximation: it is not correctly rounded, and it carries no sign, exponent or exception logic. `done_o` pulses for one cycle when `quo_o` holds the final value.

Top module: `gs_divider`

## Requirements
- R1: While `rst_ni` is low and right after reset, `busy_o` is 0, `done_o` is 0 and `quo_o` is 0.
- R2: When `start_i` is high and `busy_o` is low at a clock edge, the operands are captured and `busy_o` is high for exactly ITERS+1 cycles (4 with defaults), starting in the next cycle.
- R3: `done_o` is high for exactly one cycle: the first cycle after `busy_o` falls, i.e. ITERS+1 edges after the edge that accepted `start_i`. `done_o` and `busy_o` are never high together.
- R4: `quo_o` is unsigned fixed point with 2 integer bits and FRAC (32) fraction bits, read as `quo_o`/2^32. While `done_o` is high, it differs from the exact `num_i`/`den_i` by at most 2·2^-23, where each input is read as its 24-bit value/2^23 with bit 23 set.
- R5: `start_i` is ignored while `busy_o` is high. Operands presented then neither start a new division nor alter the running one, and the completion timing is unchanged.
- R6: While `busy_o` is low and no start is accepted, `quo_o` keeps its value, whatever happens on `num_i` and `den_i`.
- R7: A start presented in the cycle in which `done_o` is high is accepted: `busy_o` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; taken only when idle |
| num_i | input | 24 | Dividend, 1.23 fixed point, in [1,2) |
| den_i | input | 24 | Divisor, 1.23 fixed point, in [1,2) |
| busy_o | output | 1 | Prescale or refinement step in progress |
| done_o | output | 1 | One-cycle pulse: `quo_o` is final |
| quo_o | output | 34 | Quotient, 2.32 fixed point |

## Verification
The checker watches the handshake on every cycle. It confirms that an accepted start raises `busy_o` and that each busy run lasts exactly ITERS+1 cycles. It also checks that `done_o` is a single-cycle pulse that appears exactly when `busy_o` falls and never overlaps it, that `quo_o` stays frozen while idle, and that a start during the done cycle is taken. The numeric accuracy of the quotient, and the fact that operands presented while busy leave the result untouched, only show up through the bench's scenarios. These cover table-edge divisors, extreme operand pairs, pseudo-random operands and a collision of new operands with a running division, all compared against an exact real-valued quotient.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } gs_state_e;
endpackage

// File: rtl/gs_seed_rom.sv
// Reciprocal seed per divisor interval, aligned to the working fixed-point format.
module gs_seed_rom #(
  parameter int IDX_W     = 8,
  parameter int SEED_FRAC = 10,
  parameter int FRAC      = 32,
  parameter int W         = FRAC + 2
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     seed_o
);
  localparam int N      = 1 << IDX_W;
  localparam int SEED_W = SEED_FRAC + 1;
  localparam int NUMER  = 1 << (SEED_FRAC + IDX_W + 2);

  logic [SEED_W-1:0] rom [N];

  // Entry i: round(1 / interval midpoint) = round(2^SF * 2N / (2N + 2i + 1)).
  for (genvar i = 0; i < N; i++) begin : g_rom
    localparam int DEN = 2 * N + 2 * i + 1;
    assign rom[i] = SEED_W'((NUMER + DEN) / (2 * DEN));
  end

  assign seed_o = W'(rom[idx_i]) << (FRAC - SEED_FRAC);
endmodule

// File: rtl/gs_mul.sv
// Fixed-point multiply, result truncated back to the working format.
module gs_mul #(
  parameter int FRAC = 32,
  parameter int W    = FRAC + 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  assign p_o = W'(({{W{1'b0}}, a_i} * {{W{1'b0}}, b_i}) >> FRAC);
endmodule

// File: rtl/gs_ctrl.sv
// Step sequencer: step 0 prescales, steps 1..ITERS refine.
module gs_ctrl #(
  parameter int ITERS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic busy_o,
  output logic seed_sel_o,
  output logic done_o
);
  import gs_pkg::*;

  localparam int CW = $clog2(ITERS + 1);

  gs_state_e      state_q;
  logic [CW-1:0]  step_q;
  logic           done_q;

  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign busy_o     = (state_q == ST_RUN);
  assign seed_sel_o = (step_q == '0);
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            step_q  <= '0;
          end
        end
        ST_RUN: begin
          if (step_q == CW'(ITERS)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gs_divider.sv
module gs_divider #(
  parameter int IN_W      = 24,
  parameter int FRAC      = 32,
  parameter int ITERS     = 3,
  parameter int IDX_W     = 8,
  parameter int SEED_FRAC = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IN_W-1:0]    num_i,
  input  logic [IN_W-1:0]    den_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAC+1:0]    quo_o
);
  localparam int W       = FRAC + 2;
  localparam int IN_FRAC = IN_W - 1;
  localparam logic [W-1:0] TWO = W'(1) << (FRAC + 1);

  logic          load, busy, seed_sel;
  logic [W-1:0]  num_q, den_q;
  logic [W-1:0]  seed, fac;
  logic [W-1:0]  opnd [2];
  logic [W-1:0]  prod [2];

  gs_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .load_o     (load),
    .busy_o     (busy),
    .seed_sel_o (seed_sel),
    .done_o     (done_o)
  );

  gs_seed_rom #(
    .IDX_W(IDX_W), .SEED_FRAC(SEED_FRAC), .FRAC(FRAC), .W(W)
  ) u_rom (
    .idx_i  (den_q[FRAC-1 -: IDX_W]),
    .seed_o (seed)
  );

  // Step 0 scales by the seed; later steps by 2 - d.
  assign fac = seed_sel ? seed : (TWO - den_q);

  assign opnd[0] = num_q;
  assign opnd[1] = den_q;

  for (genvar k = 0; k < 2; k++) begin : g_mul
    gs_mul #(.FRAC(FRAC), .W(W)) u_mul (
      .a_i (opnd[k]),
      .b_i (fac),
      .p_o (prod[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q <= '0;
      den_q <= '0;
    end else if (load) begin
      num_q <= W'(num_i) << (FRAC - IN_FRAC);
      den_q <= W'(den_i) << (FRAC - IN_FRAC);
    end else if (busy) begin
      num_q <= prod[0];
      den_q <= prod[1];
    end
  end

  assign busy_o = busy;
  assign quo_o  = num_q;
endmodule

// File: rtl/gs_divider_chk.sv
module gs_divider_chk #(
  parameter int ITERS = 3,
  parameter int W     = 34
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quo_o
);
  localparam int LAT = ITERS + 1;
  localparam int RW  = $clog2(ITERS + 3) + 1;

  logic [RW-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  assert_busy_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_len == RW'(LAT)));

  assert_done_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(quo_o));

  assert_accept_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> busy_o);
endmodule

bind gs_divider gs_divider_chk #(.ITERS(ITERS), .W(FRAC + 2)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .quo_o   (quo_o)
);

// File: tb/gs_divider_test.sv
module gs_divider_test;
  localparam int FRAC  = 32;
  localparam int ITERS = 3;
  localparam int LAT   = ITERS + 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] num_i = '0;
  logic [23:0] den_i = '0;
  logic        busy_o, done_o;
  logic [FRAC+1:0] quo_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  gs_divider uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .num_i(num_i), .den_i(den_i),
    .busy_o(busy_o), .done_o(done_o), .quo_o(quo_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finish_run();
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // R4: compare with the exact quotient; limit is 2 units of 2^-23.
  task automatic chk_quo(input logic [23:0] n, input logic [23:0] d, input string tag);
    real exact, got, err_ulp;
    exact = (real'(n) / 8388608.0) / (real'(d) / 8388608.0);
    got   = real'(quo_o) / 4294967296.0;
    err_ulp = (got - exact) * 8388608.0;
    if (err_ulp < 0.0) err_ulp = -err_ulp;
    checks++;
    if (err_ulp > 2.0) begin
      fails++;
      $display("FAIL R4 %s n=%h d=%h: act=%f exp=%f (err %f ulp)", tag, n, d, got, exact, err_ulp);
    end
  endtask

  // Called just after a negedge with the block idle; returns at the negedge where done_o is seen.
  task automatic do_div(input logic [23:0] n, input logic [23:0] d, input string tag);
    int cyc, busy_cnt;
    num_i = n; den_i = d; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2", {tag, " busy after start"}, 64'(busy_o), 64'd1);
    cyc = 1; busy_cnt = busy_o ? 1 : 0;
    while (!done_o && cyc < 40) begin
      @(negedge clk_i);
      cyc++;
      if (busy_o) busy_cnt++;
    end
    chk("R3", {tag, " done latency"}, 64'(cyc), 64'(LAT + 1));
    chk("R2", {tag, " busy length"}, 64'(busy_cnt), 64'(LAT));
    chk("R3", {tag, " done/busy exclusive"}, 64'(busy_o), 64'd0);
    chk_quo(n, d, tag);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1", "busy in reset", 64'(busy_o), 64'd0);
    chk("R1", "done in reset", 64'(done_o), 64'd0);
    chk("R1", "quo in reset", 64'(quo_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "busy after reset", 64'(busy_o), 64'd0);
    chk("R1", "quo after reset", 64'(quo_o), 64'd0);
  endtask

  task automatic t_corners();
    do_div(24'h800000, 24'h800000, "one/one");
    do_div(24'hFFFFFF, 24'h800000, "max/one");
    do_div(24'h800000, 24'hFFFFFF, "one/max");
    do_div(24'hFFFFFF, 24'hFFFFFF, "max/max");
    do_div(24'hC00000, 24'hA00000, "1.5/1.25");
    do_div(24'h800000, 24'h800001, "one/one+ulp");
    do_div(24'hABCDEF, 24'hFF8000, "last seed slot");
    do_div(24'h955555, 24'h807FFF, "seed slot edge");
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [23:0] n, d;
      n = {1'b1, 23'($urandom)};
      d = {1'b1, 23'($urandom)};
      do_div(n, d, "random");
      @(negedge clk_i);
    end
  endtask

  // R5: new operands and start pulses during a busy run change nothing.
  task automatic t_ignore_start();
    int cyc;
    @(negedge clk_i);
    num_i = 24'hE00000; den_i = 24'h900000; start_i = 1'b1;
    @(negedge clk_i);
    num_i = 24'h812345; den_i = 24'hF00000;
    cyc = 1;
    while (!done_o && cyc < 40) begin
      if (cyc == 3) start_i = 1'b0;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    chk("R5", "latency with start while busy", 64'(cyc), 64'(LAT + 1));
    chk_quo(24'hE00000, 24'h900000, "R5 first operands kept");
    @(negedge clk_i);
    chk("R5", "no second run", 64'(busy_o), 64'd0);
  endtask

  // R6 and R3: after done, the quotient holds and done drops.
  task automatic t_hold();
    logic [FRAC+1:0] held;
    @(negedge clk_i);
    do_div(24'hB00000, 24'hD00000, "hold");
    held = quo_o;
    num_i = 24'h800000; den_i = 24'hFFFFFF;
    @(negedge clk_i);
    chk("R3", "done single cycle", 64'(done_o), 64'd0);
    repeat (5) @(negedge clk_i);
    chk("R6", "quo held while idle", 64'(quo_o), 64'(held));
    chk("R6", "still idle", 64'(busy_o), 64'd0);
  endtask

  // R7: start in the done cycle is accepted (busy checked inside do_div).
  task automatic t_back_to_back();
    @(negedge clk_i);
    do_div(24'h900000, 24'hC00000, "b2b first");
    do_div(24'hF00000, 24'h880000, "R7 b2b second");
  endtask

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_ignore_start();
    t_hold();
    t_back_to_back();
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule